// File: doc/BRIEF.md
# Masked Latched Interrupt Aggregator

The block gathers interrupt requests from five peripheral sources (four UART channels and one serial communications controller whose two channels share a single request) and merges them into one active-high interrupt line toward the host. Each source's rising edge is captured in a sticky status bit. Software clears that bit by writing a one to it.

A per-source mask and a master enable decide whether latched events reach the host line. The status bits keep latching and stay readable when the master enable is off, so software can run the peripherals in polled mode. A force control bit raises the host line regardless of the sources, which lets interrupt handlers be exercised during bring-up.

Software reaches three 32-bit word registers through a simple read/write port:
- status at byte offset 0x00,
- control at 0x04,
- mask at 0x08.

Top module: `intr_collector`

## Requirements
- R1: After synchronous reset, the status, mask and control registers are 0, `host_irq` is 0 and `rdata` is 0.
- R2: A 0-to-1 transition on `src_irq[i]` sets status bit i on the clock edge that samples it high. Bits 0..3 are UART channels A..D and bit 4 is the serial controller. A source held high sets its bit only once.
- R3: A write to offset 0x00 clears each status bit whose `wdata` bit is 1. A `wdata` bit of 0 leaves the corresponding status bit unchanged.
- R4: When a rising source edge and a clearing write of the same status bit occur in one cycle, the bit ends up set.
- R5: The mask register at offset 0x08 holds one enable per source in bits 4:0. Bits 31:5 are spare and read back as 0.
- R6: The control register at offset 0x04 holds the master enable in bit 0 and force in bit 1. Bits 31:2 read back as 0.
- R7: `host_irq` is registered. On each edge it takes force OR (master enable AND any bit of status AND mask), using the register values held before that edge.
- R8: With the master enable at 0, status bits still latch and read back, and `host_irq` follows only the force bit.
- R9: A read with `rd_en` high loads `rdata` on the next edge with the addressed register, zero-extended. Reads of offset 0x0C read 0. `addr[1:0]` is ignored. `rdata` holds its value when `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | 5 | Level interrupt requests from the sources |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| host_irq | output | 1 | Registered interrupt request to the host |

## Verification
The assertions check several properties on every cycle:
- the host request equals the registered combination of force, enable, status and mask;
- every captured edge appears in status one edge later;
- no status bit falls without a write;
- spare read bits stay 0.

Other behaviours depend on specific stimulus and only the bench scenarios can show them:
- the set-wins collision;
- that a held level does not set its bit a second time;
- zero-write immunity;
- polling with the enable off;
- the decode of each offset.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int WORD_STATUS = 0;
  localparam int WORD_CTRL   = 1;
  localparam int WORD_MASK   = 2;
  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_FORCE_BIT = 1;
  localparam int CTRL_W         = 2;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src,
  output logic [N-1:0] rise
);
  logic [N-1:0] src_q;

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= src;
  end

  assign rise = src & ~src_q;
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] status
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)             status[i] <= 1'b0;
        else if (set_vec[i]) status[i] <= 1'b1;
        else if (clr_vec[i]) status[i] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] status,
  input  logic [N-1:0] mask,
  input  logic         enable,
  input  logic         force_req,
  output logic         irq
);
  logic pending;
  assign pending = |(status & mask);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= force_req | (enable & pending);
  end
endmodule

// File: rtl/intr_collector.sv
module intr_collector
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC-1:0]  src_irq,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic                host_irq
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]  word;
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] mask_q;
  logic [CTRL_W-1:0]  ctrl_q;
  logic [DATA_W-1:0]  rd_next;

  assign word = addr[ADDR_W-1:2];

  irq_edge_detect #(.N(NUM_SRC)) u_edge (
    .clk(clk), .rst(rst), .src(src_irq), .rise(rise)
  );

  assign clr_vec = (wr_en && word == WORD_W'(WORD_STATUS)) ? wdata[NUM_SRC-1:0] : '0;

  irq_status_bank #(.N(NUM_SRC)) u_status (
    .clk(clk), .rst(rst), .set_vec(rise), .clr_vec(clr_vec), .status(status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      if (word == WORD_W'(WORD_MASK)) mask_q <= wdata[NUM_SRC-1:0];
      if (word == WORD_W'(WORD_CTRL)) ctrl_q <= wdata[CTRL_W-1:0];
    end
  end

  irq_req_gen #(.N(NUM_SRC)) u_req (
    .clk(clk), .rst(rst), .status(status), .mask(mask_q),
    .enable(ctrl_q[CTRL_EN_BIT]), .force_req(ctrl_q[CTRL_FORCE_BIT]),
    .irq(host_irq)
  );

  always_comb begin
    rd_next = '0;
    case (word)
      WORD_W'(WORD_STATUS): rd_next[NUM_SRC-1:0] = status;
      WORD_W'(WORD_CTRL):   rd_next[CTRL_W-1:0]  = ctrl_q;
      WORD_W'(WORD_MASK):   rd_next[NUM_SRC-1:0] = mask_q;
      default:              rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int N      = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [N-1:0]      rise,
  input logic [N-1:0]      status,
  input logic [N-1:0]      mask,
  input logic              en,
  input logic              frc,
  input logic              wr_en,
  input logic              host_irq,
  input logic [DATA_W-1:0] rdata
);
  // R2
  edge_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (rise != '0) |=> ((status & $past(rise)) == $past(rise)));

  // R3
  no_silent_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en) |=> ((status & $past(status)) == $past(status)));

  // R7
  host_req_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (host_irq == $past(frc | (en & (|(status & mask))))));

  // R5
  spare_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rdata[DATA_W-1:N] == '0);

  // R8
  enable_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !frc) |=> !host_irq);
endmodule

bind intr_collector irq_agg_chk #(.N(NUM_SRC), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rise(rise), .status(status), .mask(mask_q),
  .en(ctrl_q[0]), .frc(ctrl_q[1]), .wr_en(wr_en),
  .host_irq(host_irq), .rdata(rdata)
);

// File: tb/sim_intr_collector.sv
module sim_intr_collector;
  localparam int N = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] src_irq = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        host_irq;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [N-1:0] m_st, m_msk, m_prev;
  logic [1:0]   m_ctl;
  logic [31:0]  m_rd;
  logic         m_irq;

  intr_collector u0 (
    .clk(clk), .rst(rst), .src_irq(src_irq), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .host_irq(host_irq)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] read_val(input logic [3:0] a);
    case (a[3:2])
      2'd0: return {27'd0, m_st};
      2'd1: return {30'd0, m_ctl};
      2'd2: return {27'd0, m_msk};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic next_irq();
    return m_ctl[1] | (m_ctl[0] & (|(m_st & m_msk)));
  endfunction

  task automatic model_reset();
    m_st = '0; m_msk = '0; m_prev = '0; m_ctl = '0; m_rd = '0; m_irq = 1'b0;
  endtask

  task automatic model_edge();
    logic [N-1:0] rise;
    m_rd  = rd_en ? read_val(addr) : m_rd;
    m_irq = next_irq();
    rise  = src_irq & ~m_prev;
    m_prev = src_irq;
    if (wr_en && addr[3:2] == 2'd0) m_st = m_st & ~wdata[N-1:0];
    m_st = m_st | rise;
    if (wr_en && addr[3:2] == 2'd2) m_msk = wdata[N-1:0];
    if (wr_en && addr[3:2] == 2'd1) m_ctl = wdata[1:0];
  endtask

  task automatic check(input string tag);
    checks++;
    if (host_irq !== m_irq) begin
      fails++;
      $display("FAIL %s host_irq actual=%0b expected=%0b", tag, host_irq, m_irq);
    end
    checks++;
    if (rdata !== m_rd) begin
      fails++;
      $display("FAIL %s rdata actual=%h expected=%h", tag, rdata, m_rd);
    end
  endtask

  task automatic cycle(input logic [N-1:0] s, input logic w, input logic r,
                       input logic [3:0] a, input logic [31:0] d, input string tag);
    src_irq = s; wr_en = w; rd_en = r; addr = a; wdata = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1");
    // R1 reset values of every register
    cycle('0, 0, 1, 4'h0, 0, "R1");
    cycle('0, 0, 1, 4'h4, 0, "R1");
    cycle('0, 0, 1, 4'h8, 0, "R1");
    // R2 edge on UART A, then hold, clear, confirm held level does not re-set
    cycle(5'b00001, 0, 0, 4'h0, 0, "R2");
    cycle(5'b00001, 0, 1, 4'h0, 0, "R2");
    cycle(5'b00001, 1, 0, 4'h0, 32'h1, "R2");
    cycle(5'b00001, 0, 1, 4'h0, 0, "R2");
    cycle(5'b10000, 0, 0, 4'h0, 0, "R2");
    cycle(5'b10000, 0, 1, 4'h0, 0, "R2");
    // R3 writing zeros has no effect, ones clear
    cycle(5'b00000, 1, 0, 4'h0, 32'h0, "R3");
    cycle(5'b00000, 0, 1, 4'h0, 0, "R3");
    cycle(5'b00000, 1, 0, 4'h1, 32'hFFFF_FFEF, "R3");
    cycle(5'b00000, 0, 1, 4'h0, 0, "R3");
    cycle(5'b00000, 1, 0, 4'h0, 32'h10, "R3");
    cycle(5'b00000, 0, 1, 4'h0, 0, "R3");
    // R4 set wins against simultaneous clear
    cycle(5'b00100, 0, 0, 4'h0, 0, "R4");
    cycle(5'b00000, 0, 0, 4'h0, 0, "R4");
    cycle(5'b00100, 1, 0, 4'h0, 32'h4, "R4");
    cycle(5'b00100, 0, 1, 4'h0, 0, "R4");
    // R5 mask spare bits read 0
    cycle(5'b00100, 1, 0, 4'h8, 32'hFFFF_FFFF, "R5");
    cycle(5'b00100, 0, 1, 4'h8, 0, "R5");
    // R8 enable off: status readable, no request
    cycle(5'b01100, 0, 1, 4'h0, 0, "R8");
    cycle(5'b01100, 0, 1, 4'h0, 0, "R8");
    // R6 control readback and force with mask cleared
    cycle(5'b00000, 1, 0, 4'h4, 32'hFFFF_FFFD, "R6");
    cycle(5'b00000, 0, 1, 4'h4, 0, "R6");
    cycle(5'b00000, 0, 0, 4'h4, 0, "R7");
    cycle(5'b00000, 1, 0, 4'h8, 32'h0, "R6");
    cycle(5'b00000, 1, 0, 4'h4, 32'h2, "R6");
    cycle(5'b00000, 0, 1, 4'h4, 0, "R6");
    cycle(5'b00000, 0, 0, 4'h4, 0, "R6");
    // R9 unmapped offset and hold when rd_en low
    cycle(5'b00000, 0, 1, 4'hC, 0, "R9");
    cycle(5'b00000, 0, 0, 4'h0, 0, "R9");
    cycle(5'b00000, 0, 1, 4'h3, 0, "R9");
    // R7 random traffic
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] a;
      a = {2'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
      cycle(N'($urandom), ($urandom_range(0, 9) < 3), ($urandom_range(0, 1) == 1),
            a, $urandom, "R7");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule